// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel. It copies a buffer from a source address to a destination address over a simple single-master memory bus. Each copy step is one bus read of 1, 2 or 4 bytes followed by one bus write of the same size. After each step, the source pointer and the destination pointer each move independently. A pointer can stay where it is, move up by the step size or move down by the step size. Holding the destination fixed lets the channel feed a peripheral data register. A length counter tracks how many steps are left in the current buffer.

In direct mode the channel stops when the length reaches zero. In chained mode it first reads a 16-byte descriptor from memory at the list pointer, as four word reads. The descriptor reloads the source, destination, length/control word and the next list pointer. The channel keeps walking the chain until it finishes a descriptor marked as the last one. Setup goes through a small register-write port that is only accepted while the channel is idle. Completion is signalled by a one-cycle `done` pulse and a fault by a one-cycle `error` pulse.

Register index map on `regAddr`:
- 0 holds the source pointer.
- 1 holds the destination pointer.
- 2 holds the control word.
- 3 holds the list pointer.
- 4 is the command. Writing bit 0 starts direct mode. Writing bit 1 starts chained mode, and bit 1 wins if both bits are set.

Control word fields, which are also word 2 of a descriptor:
- Bits [15:0] hold the length, counted in transfers.
- Bits [17:16] hold the source pointer mode and bits [19:18] the destination pointer mode. In both fields 0 holds, 1 increments, 2 decrements and 3 holds.
- Bits [21:20] hold the size code: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 4 bytes.
- Bit 22 is the last-descriptor flag.

Descriptor word order at increasing addresses: source, destination, control word, next list pointer.

Top module: `dmaChannel`

## Requirements
- R1: After reset `busy`, `busReq`, `done` and `error` are all low.
- R2: With both pointer modes set to increment, transfer k reads from source+k·S and writes to destination+k·S. S is 1, 2 or 4 bytes for size codes 0, 1 and 2, and `busSize` carries the size code.
- R3: A pointer in decrement mode (mode 2) addresses base−k·S on transfer k.
- R4: A pointer in hold mode (mode 0) uses the same address on every transfer. With the destination held, the location keeps the data of the final transfer.
- R5: Each transfer is exactly one read followed by one write. While `busReady` is low, `busReq`, `busWe`, `busAddr` and `busSize` hold their values.
- R6: A buffer of length N performs exactly N transfers. The channel then ends with `busy` low and no bus request.
- R7: A length of zero completes without any data transfer, both at a direct start and for a loaded descriptor.
- R8: A chained start reads the descriptor as four 4-byte reads (size code 2) at L, L+4, L+8 and L+12. It loads them as source, destination, control word and next list pointer.
- R9: A chain follows each next list pointer after a buffer ends, until a buffer whose last flag (bit 22) is set. `done` pulses once, after that final buffer.
- R10: A list pointer whose low 4 bits are nonzero raises `error` with no descriptor read. This holds at a chained start and when moving to the next descriptor.
- R11: Register writes made while `busy` is high have no effect on the running transfer.
- R12: `done` and `error` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWdata | input | 32 | Register write data |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | 32 | Byte address |
| busSize | output | 2 | Access size code (0:1, 1:2, 2:4 bytes) |
| busWdata | output | 32 | Write data, valid bytes in the low lanes |
| busRdata | input | 32 | Read data, low lanes first |
| busReady | input | 1 | Access completes at this clock edge |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle misaligned-list pulse |
| busy | output | 1 | Channel is running |

## Verification
The assertions assume that the bus never raises `busReady` without a pending request that is completed at that edge. They also assume that register writes arrive only through the write port. The responder in the bench raises ready only while `busReq` is high and finishes the access in that same cycle. It inserts zero to two wait cycles, so the hold checks see stalls. The bench keeps source, destination and descriptor regions apart and never lets a pointer wrap past the ends of its 256-byte memory.

// File: rtl/dmaChanPkg.sv
package dmaChanPkg;

  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] REG_SRC  = 3'd0;
  localparam logic [REG_IDX_W-1:0] REG_DST  = 3'd1;
  localparam logic [REG_IDX_W-1:0] REG_CTRL = 3'd2;
  localparam logic [REG_IDX_W-1:0] REG_LIST = 3'd3;
  localparam logic [REG_IDX_W-1:0] REG_CMD  = 3'd4;

  // control word field positions (shared by register and descriptor word 2)
  localparam int LEN_LSB   = 0;
  localparam int SMODE_LSB = 16;
  localparam int DMODE_LSB = 18;
  localparam int SIZE_LSB  = 20;
  localparam int LAST_BIT  = 22;

  localparam logic [1:0] MODE_UP   = 2'd1;
  localparam logic [1:0] MODE_DOWN = 2'd2;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_LIST = 2'd2;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EVAL,
    ST_READ,
    ST_WRITE
  } chanState_e;

  typedef struct packed {
    logic       regOpen;
    logic       latchData;
    logic       stepXfer;
    logic       descLoad;
    logic [1:0] descIdx;
    logic [1:0] addrSel;
  } dpStrobe_t;

endpackage

// File: rtl/dmaPtrStep.sv
module dmaPtrStep #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] curPtr,
  input  logic [1:0]    mode,
  input  logic [1:0]    sizeCode,
  output logic [AW-1:0] nextPtr
);
  import dmaChanPkg::*;

  logic [AW-1:0] stepBytes;

  always_comb begin
    unique case (sizeCode)
      2'd0:    stepBytes = AW'(1);
      2'd1:    stepBytes = AW'(2);
      default: stepBytes = AW'(4);
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_UP:   nextPtr = curPtr + stepBytes;
      MODE_DOWN: nextPtr = curPtr - stepBytes;
      default:   nextPtr = curPtr;
    endcase
  end

endmodule

// File: rtl/dmaChanDatapath.sv
module dmaChanDatapath
  import dmaChanPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [WORD_W-1:0]    regWdata,
  input  dpStrobe_t            strobe,
  input  logic [WORD_W-1:0]    busRdata,
  output logic [WORD_W-1:0]    busAddr,
  output logic [WORD_W-1:0]    busWdata,
  output logic [1:0]           xferSize,
  output logic                 lenZero,
  output logic                 lastDesc,
  output logic                 listMisaligned
);

  localparam int N_PTR = 2;

  logic [WORD_W-1:0] ptrCur  [N_PTR];
  logic [WORD_W-1:0] ptrNext [N_PTR];
  logic [1:0]        ptrMode [N_PTR];
  logic [WORD_W-1:0] listPtr;
  logic [WORD_W-1:0] dataHold;
  logic [LEN_W-1:0]  lenCnt;
  logic [1:0]        sizeCode;
  logic              lastFlag;

  logic              regHit;
  logic              ctrlLoad;
  logic [WORD_W-1:0] ctrlWord;
  logic [WORD_W-1:0] fetchAddr;

  // one stepping unit per pointer (0: source, 1: destination)
  for (genvar g = 0; g < N_PTR; g++) begin : gStep
    dmaPtrStep #(.AW(WORD_W)) uStep (
      .curPtr  (ptrCur[g]),
      .mode    (ptrMode[g]),
      .sizeCode(sizeCode),
      .nextPtr (ptrNext[g])
    );
  end

  assign regHit   = strobe.regOpen && regWe;
  assign ctrlLoad = (regHit && regAddr == REG_CTRL) ||
                    (strobe.descLoad && strobe.descIdx == 2'd2);
  assign ctrlWord = strobe.descLoad ? busRdata : regWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrCur[0]  <= '0;
      ptrCur[1]  <= '0;
      ptrMode[0] <= '0;
      ptrMode[1] <= '0;
      listPtr    <= '0;
      dataHold   <= '0;
      lenCnt     <= '0;
      sizeCode   <= '0;
      lastFlag   <= 1'b0;
    end else begin
      if (regHit) begin
        case (regAddr)
          REG_SRC:  ptrCur[0] <= regWdata;
          REG_DST:  ptrCur[1] <= regWdata;
          REG_LIST: listPtr   <= regWdata;
          default: ;
        endcase
      end
      if (strobe.descLoad) begin
        case (strobe.descIdx)
          2'd0:    ptrCur[0] <= busRdata;
          2'd1:    ptrCur[1] <= busRdata;
          2'd3:    listPtr   <= busRdata;
          default: ;
        endcase
      end
      if (ctrlLoad) begin
        lenCnt     <= ctrlWord[LEN_LSB +: LEN_W];
        ptrMode[0] <= ctrlWord[SMODE_LSB +: 2];
        ptrMode[1] <= ctrlWord[DMODE_LSB +: 2];
        sizeCode   <= ctrlWord[SIZE_LSB +: 2];
        lastFlag   <= ctrlWord[LAST_BIT];
      end
      if (strobe.latchData) begin
        dataHold <= busRdata;
      end
      if (strobe.stepXfer) begin
        ptrCur[0] <= ptrNext[0];
        ptrCur[1] <= ptrNext[1];
        lenCnt    <= lenCnt - LEN_W'(1);
      end
    end
  end

  assign fetchAddr = listPtr + WORD_W'({strobe.descIdx, 2'b00});

  always_comb begin
    unique case (strobe.addrSel)
      SEL_SRC:  busAddr = ptrCur[0];
      SEL_DST:  busAddr = ptrCur[1];
      default:  busAddr = fetchAddr;
    endcase
  end

  assign busWdata       = dataHold;
  assign xferSize       = (sizeCode == 2'd3) ? SIZE_WORD : sizeCode;
  assign lenZero        = (lenCnt == '0);
  assign lastDesc       = lastFlag;
  assign listMisaligned = |listPtr[3:0];

endmodule

// File: rtl/dmaChanCtrl.sv
module dmaChanCtrl
  import dmaChanPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWe,
  input  logic [1:0] cmdBits,
  input  logic      lenZero,
  input  logic      lastDesc,
  input  logic      listMisaligned,
  input  logic      busReady,
  input  logic [1:0] xferSize,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      busWe,
  output logic [1:0] busSize,
  output logic      done,
  output logic      error,
  output logic      busy
);

  chanState_e state, nextState;
  logic [1:0] descIdx, nextIdx;
  logic       linkedRun, nextLinked;
  logic       setDone, setErr;

  always_comb begin
    nextState      = state;
    nextIdx        = descIdx;
    nextLinked     = linkedRun;
    setDone        = 1'b0;
    setErr         = 1'b0;
    strobe         = '0;
    strobe.regOpen = (state == ST_IDLE);
    strobe.descIdx = descIdx;
    strobe.addrSel = SEL_SRC;
    busReq         = 1'b0;
    busWe          = 1'b0;
    busSize        = xferSize;

    unique case (state)
      ST_IDLE: begin
        if (cmdWe && cmdBits[1]) begin
          nextLinked = 1'b1;
          if (listMisaligned) begin
            setErr = 1'b1;
          end else begin
            nextIdx   = 2'd0;
            nextState = ST_FETCH;
          end
        end else if (cmdWe && cmdBits[0]) begin
          nextLinked = 1'b0;
          nextState  = ST_EVAL;
        end
      end
      ST_FETCH: begin
        busReq          = 1'b1;
        busSize         = SIZE_WORD;
        strobe.addrSel  = SEL_LIST;
        strobe.descLoad = busReady;
        if (busReady) begin
          nextIdx = descIdx + 2'd1;
          if (descIdx == 2'd3) begin
            nextState = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        if (!lenZero) begin
          nextState = ST_READ;
        end else if (linkedRun && !lastDesc) begin
          if (listMisaligned) begin
            setErr    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            nextIdx   = 2'd0;
            nextState = ST_FETCH;
          end
        end else begin
          setDone   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_READ: begin
        busReq           = 1'b1;
        strobe.addrSel   = SEL_SRC;
        strobe.latchData = busReady;
        if (busReady) begin
          nextState = ST_WRITE;
        end
      end
      ST_WRITE: begin
        busReq          = 1'b1;
        busWe           = 1'b1;
        strobe.addrSel  = SEL_DST;
        strobe.stepXfer = busReady;
        if (busReady) begin
          nextState = ST_EVAL;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      descIdx   <= '0;
      linkedRun <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      state     <= nextState;
      descIdx   <= nextIdx;
      linkedRun <= nextLinked;
      done      <= setDone;
      error     <= setErr;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dmaChannel.sv
module dmaChannel
  import dmaChanPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [WORD_W-1:0]    regWdata,
  output logic                 busReq,
  output logic                 busWe,
  output logic [WORD_W-1:0]    busAddr,
  output logic [1:0]           busSize,
  output logic [WORD_W-1:0]    busWdata,
  input  logic [WORD_W-1:0]    busRdata,
  input  logic                 busReady,
  output logic                 done,
  output logic                 error,
  output logic                 busy
);

  dpStrobe_t  strobe;
  logic [1:0] xferSize;
  logic       lenZero;
  logic       lastDesc;
  logic       listMisaligned;
  logic       cmdWe;

  assign cmdWe = regWe && (regAddr == REG_CMD);

  dmaChanCtrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .cmdWe         (cmdWe),
    .cmdBits       (regWdata[1:0]),
    .lenZero       (lenZero),
    .lastDesc      (lastDesc),
    .listMisaligned(listMisaligned),
    .busReady      (busReady),
    .xferSize      (xferSize),
    .strobe        (strobe),
    .busReq        (busReq),
    .busWe         (busWe),
    .busSize       (busSize),
    .done          (done),
    .error         (error),
    .busy          (busy)
  );

  dmaChanDatapath #(.WORD_W(WORD_W), .LEN_W(LEN_W)) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .regWe         (regWe),
    .regAddr       (regAddr),
    .regWdata      (regWdata),
    .strobe        (strobe),
    .busRdata      (busRdata),
    .busAddr       (busAddr),
    .busWdata      (busWdata),
    .xferSize      (xferSize),
    .lenZero       (lenZero),
    .lastDesc      (lastDesc),
    .listMisaligned(listMisaligned)
  );

endmodule

// File: rtl/dmaChannelChecker.sv
module dmaChannelChecker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWe,
  input logic [WORD_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busReady,
  input logic              done,
  input logic              error,
  input logic              busy
);

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq); // R1

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busWe) && $stable(busAddr) && $stable(busSize))); // R5

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && !$past(busWe)) |-> $past(busReq && !busWe && busReady)); // R5

  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> (!busy && !busReq)); // R6

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !$past(busReq)); // R10

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    error |=> !error); // R12

endmodule

bind dmaChannel dmaChannelChecker #(.WORD_W(WORD_W)) uChk (.*);

// File: tb/dmaChannel_test.sv
module dmaChannel_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata;
  logic        busReq, busWe, busReady;
  logic [31:0] busAddr, busWdata, busRdata;
  logic [1:0]  busSize;
  logic        done, error, busy;

  always #10 clk = ~clk;

  dmaChannel uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .done(done), .error(error), .busy(busy)
  );

  logic [7:0] mem    [256];
  logic [7:0] expMem [256];
  logic [7:0] logAddr [128];
  logic       logWe   [128];
  logic [1:0] logSz   [128];
  logic [7:0] expAddr [128];
  logic       expWe   [128];
  logic [1:0] expSz   [128];
  int logCnt, expCnt;
  int doneCnt, errCnt, pulseBad;
  int total = 0, bad = 0;
  int waitLeft = 0, waitSeed = 0, cyc = 0;
  logic prevDone = 0, prevErr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus responder: decides ready and performs the access at the falling edge
  always @(negedge clk) begin
    if (!rstN || !busReq) begin
      busReady = 1'b0;
    end else if (waitLeft == 0) begin
      busReady = 1'b1;
      busRdata = {mem[busAddr[7:0]+8'd3], mem[busAddr[7:0]+8'd2],
                  mem[busAddr[7:0]+8'd1], mem[busAddr[7:0]]};
      if (busWe) begin
        for (int b = 0; b < (1 << busSize); b++)
          mem[busAddr[7:0] + 8'(b)] = busWdata[8*b +: 8];
      end
      if (logCnt < 128) begin
        logAddr[logCnt] = busAddr[7:0];
        logWe[logCnt]   = busWe;
        logSz[logCnt]   = busSize;
      end
      logCnt++;
      waitSeed++;
      waitLeft = waitSeed % 3;
    end else begin
      busReady = 1'b0;
      waitLeft--;
    end
  end

  // pulse monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (done) doneCnt++;
      if (error) errCnt++;
      if ((done && prevDone) || (error && prevErr) || (done && error)) pulseBad++;
    end
    prevDone = done;
    prevErr  = error;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(int len, int sm, int dm, int sz, int last);
    return 32'(len) | (32'(sm) << 16) | (32'(dm) << 18) | (32'(sz) << 20) | (32'(last) << 22);
  endfunction

  function automatic int dirOf(int m);
    return (m == 1) ? 1 : (m == 2) ? -1 : 0;
  endfunction

  task automatic putWord(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) mem[(a + b) & 255] = w[8*b +: 8];
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + seed * 13 + 3) & 255);
  endtask

  task automatic snapshot();
    for (int i = 0; i < 256; i++) expMem[i] = mem[i];
    expCnt = 0;
  endtask

  task automatic expAccess(input int a, input bit we, input int sz);
    if (expCnt < 128) begin
      expAddr[expCnt] = 8'(a);
      expWe[expCnt]   = we;
      expSz[expCnt]   = 2'(sz);
    end
    expCnt++;
  endtask

  task automatic expFetch(input int lar);
    for (int i = 0; i < 4; i++) expAccess(lar + 4 * i, 1'b0, 2);
  endtask

  task automatic modelXfer(input int src, input int dst, input int sm, input int dm,
                           input int sz, input int len);
    int step;
    logic [7:0] tmp [4];
    step = 1 << sz;
    for (int k = 0; k < len; k++) begin
      int sa, da;
      sa = (src + dirOf(sm) * step * k) & 255;
      da = (dst + dirOf(dm) * step * k) & 255;
      expAccess(sa, 1'b0, sz);
      for (int b = 0; b < step; b++) tmp[b] = expMem[(sa + b) & 255];
      for (int b = 0; b < step; b++) expMem[(da + b) & 255] = tmp[b];
      expAccess(da, 1'b1, sz);
    end
  endtask

  task automatic clearRun();
    @(negedge clk);
    logCnt = 0; doneCnt = 0; errCnt = 0;
  endtask

  task automatic waitEnd();
    int n;
    n = 0;
    while ((doneCnt + errCnt) == 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string memTag, input string endTag, input int expDone, input int expErr);
    int firstBad, firstMem;
    chk(logCnt == expCnt, "R6 access count", logCnt, expCnt);
    firstBad = -1;
    for (int i = 0; i < expCnt && i < logCnt && i < 128; i++)
      if (firstBad < 0 && (logAddr[i] != expAddr[i] || logWe[i] != expWe[i] || logSz[i] != expSz[i]))
        firstBad = i;
    chk(firstBad < 0, "R5 access order",
        (firstBad < 0) ? 0 : {logWe[firstBad], logSz[firstBad], logAddr[firstBad]},
        (firstBad < 0) ? 0 : {expWe[firstBad], expSz[firstBad], expAddr[firstBad]});
    firstMem = -1;
    for (int i = 0; i < 256; i++) if (firstMem < 0 && mem[i] !== expMem[i]) firstMem = i;
    chk(firstMem < 0, memTag, (firstMem < 0) ? 0 : mem[firstMem], (firstMem < 0) ? 0 : expMem[firstMem]);
    chk(doneCnt == expDone, {endTag, " done pulses"}, doneCnt, expDone);
    chk(errCnt == expErr, {endTag, " error pulses"}, errCnt, expErr);
    chk(!busy && !busReq, "R6 idle after end", {busy, busReq}, 0);
  endtask

  initial begin
    int seed;
    regWe = 0; regAddr = 0; regWdata = 0; busRdata = 0; busReady = 0;
    logCnt = 0; doneCnt = 0; errCnt = 0; pulseBad = 0; expCnt = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !busReq && !done && !error, "R1 reset state", {busy, busReq, done, error}, 0);

    // sweep: every size, source mode, destination mode, two lengths
    seed = 0;
    for (int sz = 0; sz < 3; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++)
          for (int li = 0; li < 2; li++) begin
            int len;
            string tag;
            len = (li == 0) ? 1 : 3;
            seed++;
            tag = (sm == 2 || dm == 2) ? "R3 decrement copy" :
                  (sm == 0 || dm == 0) ? "R4 hold copy" : "R2 increment copy";
            fillMem(seed);
            snapshot();
            modelXfer(32'h58, 32'hB0, sm, dm, sz, len);
            wrReg(3'd0, 32'h58);
            wrReg(3'd1, 32'hB0);
            wrReg(3'd2, ctrlWord(len, sm, dm, sz, 0));
            clearRun();
            wrReg(3'd4, 32'h1);
            waitEnd();
            compare(tag, "R6", 1, 0);
          end

    // R7: direct start with zero length
    fillMem(90);
    snapshot();
    wrReg(3'd0, 32'h40);
    wrReg(3'd1, 32'h90);
    wrReg(3'd2, ctrlWord(0, 1, 1, 2, 0));
    clearRun();
    wrReg(3'd4, 32'h1);
    waitEnd();
    compare("R7 zero length memory", "R7", 1, 0);

    // R8/R9: three-descriptor chain
    fillMem(91);
    putWord(8'h00, 32'h40); putWord(8'h04, 32'h90); putWord(8'h08, ctrlWord(3, 1, 1, 1, 0)); putWord(8'h0C, 32'h10);
    putWord(8'h10, 32'h70); putWord(8'h14, 32'hA0); putWord(8'h18, ctrlWord(2, 2, 0, 0, 0)); putWord(8'h1C, 32'h20);
    putWord(8'h20, 32'h50); putWord(8'h24, 32'hC0); putWord(8'h28, ctrlWord(2, 1, 2, 2, 1)); putWord(8'h2C, 32'h33);
    snapshot();
    expFetch(8'h00); modelXfer(32'h40, 32'h90, 1, 1, 1, 3);
    expFetch(8'h10); modelXfer(32'h70, 32'hA0, 2, 0, 0, 2);
    expFetch(8'h20); modelXfer(32'h50, 32'hC0, 1, 2, 2, 2);
    wrReg(3'd3, 32'h00);
    clearRun();
    wrReg(3'd4, 32'h2);
    waitEnd();
    compare("R8 chained copy memory", "R9", 1, 0);

    // R7/R9: zero-length non-last descriptor skips to the next one
    fillMem(92);
    putWord(8'h30, 32'h44); putWord(8'h34, 32'h94); putWord(8'h38, ctrlWord(0, 1, 1, 0, 0)); putWord(8'h3C, 32'h20);
    putWord(8'h20, 32'h50); putWord(8'h24, 32'hC0); putWord(8'h28, ctrlWord(1, 1, 1, 0, 1)); putWord(8'h2C, 32'h00);
    snapshot();
    expFetch(8'h30); expFetch(8'h20); modelXfer(32'h50, 32'hC0, 1, 1, 0, 1);
    wrReg(3'd3, 32'h30);
    clearRun();
    wrReg(3'd4, 32'h3);
    waitEnd();
    compare("R7 zero-length descriptor memory", "R9", 1, 0);

    // R10: misaligned list pointer at start
    fillMem(93);
    snapshot();
    wrReg(3'd3, 32'h04);
    clearRun();
    wrReg(3'd4, 32'h2);
    waitEnd();
    compare("R10 misaligned start memory", "R10", 0, 1);

    // R10: misaligned next pointer after a buffer
    fillMem(94);
    putWord(8'h30, 32'h48); putWord(8'h34, 32'h98); putWord(8'h38, ctrlWord(1, 1, 1, 2, 0)); putWord(8'h3C, 32'h14);
    snapshot();
    expFetch(8'h30); modelXfer(32'h48, 32'h98, 1, 1, 2, 1);
    wrReg(3'd3, 32'h30);
    clearRun();
    wrReg(3'd4, 32'h2);
    waitEnd();
    compare("R10 misaligned next memory", "R10", 0, 1);

    // R11: register writes while running are ignored
    fillMem(95);
    snapshot();
    modelXfer(32'h60, 32'hB8, 1, 1, 0, 3);
    wrReg(3'd0, 32'h60);
    wrReg(3'd1, 32'hB8);
    wrReg(3'd2, ctrlWord(3, 1, 1, 0, 0));
    clearRun();
    wrReg(3'd4, 32'h1);
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    wrReg(3'd0, 32'h10);
    wrReg(3'd1, 32'h20);
    wrReg(3'd2, ctrlWord(9, 2, 2, 2, 0));
    waitEnd();
    compare("R11 copy unaffected", "R11", 1, 0);

    chk(pulseBad == 0, "R12 pulse shape", pulseBad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule